// File: doc/BRIEF.md
# Oversampling Serial Receive Channel

This block receives an asynchronous single-wire serial stream by sampling it at a programmable multiple of the bit rate. The sample strobe comes from the reference clock through an integer divider. Every group of samples is packed into one byte, with the earliest sample in the most significant bit. The byte is handed to a polling consumer through a data register and a valid flag. At the default setting of eight samples per bit, one transmitted bit becomes one full byte: `0xFF` for a steady high bit and `0x00` for a steady low bit. The consumer recovers the original bits by downsampling these bytes.

The consumer watches `rx_valid`, reads `rx_byte` and then pulses `rx_clear` for one cycle. The flag drops in the very next cycle, so a consumer that polls again immediately never reads the same byte twice. Back-pressure does not exist. The producer never waits, so a byte that completes while the previous one is still unread replaces it and raises `rx_overrun`. When `en` is low, the divider phase, the sample count and any partial byte are held at zero. Capture therefore restarts on a clean byte boundary.

Top module: `osr_rx_chan`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_overrun` is 0 and `rx_byte` is 0.
- R2: `cfg_word[31:16]` holds a divider value D, and one sample is taken every D+1 reference cycles. The serial input passes through two synchronizer flops. With eight samples per byte, the first byte becomes valid 8*(D+1) cycles after `en` rises.
- R3: `cfg_word[15:0]` holds a code C, and one byte is emitted every C+1 samples. Codes above 7 act as 7, and code 7 gives eight samples per byte.
- R4: Samples fill the byte from bit 7 downwards, one bit per sample, with a high input read as 1. Bits below the last sample of a short group are 0; with C=3, a high bit gives `0xF0`.
- R5: At eight samples per bit with aligned bit timing, the transmitted value 0xA3 arrives as the bytes FF 00 FF 00 00 00 FF FF, in that order.
- R6: `rx_valid` rises in the cycle after the clock edge on which a byte is latched. It stays high until a clear, and `rx_byte` changes only when a new byte is latched.
- R7: A clear with no new byte arriving lowers `rx_valid` in the next cycle. A consumer that reads and clears on every cycle it sees the flag receives each byte exactly once.
- R8: If a byte completes on the same edge as a clear, the new byte is kept, `rx_valid` stays high and `rx_overrun` is not raised.
- R9: If a byte completes while `rx_valid` is high and no clear is given, `rx_overrun` goes to 1 and `rx_byte` takes the newer byte. A later clear lowers both flags.
- R10: A clear while `rx_valid` is low has no effect on the flags or on the bytes that follow.
- R11: While `en` is low, the divider, the sample count and the partial byte are reset. After re-enabling, capture starts on a fresh byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable; low resets divider phase and sample grouping |
| cfg_word | input | 32 | Divider value in [31:16], samples-per-byte code in [15:0] |
| rx_serial | input | 1 | Asynchronous serial line |
| rx_clear | input | 1 | One-cycle strobe that clears the valid and overrun flags |
| rx_byte | output | 8 | Last completed sample byte |
| rx_valid | output | 1 | A byte is waiting to be read |
| rx_overrun | output | 1 | A byte was replaced before it was cleared |

## Verification
A mixed bit pattern (0xA3) at eight samples per bit, read by a consumer that clears and re-polls every cycle, shows both the sample order and any duplication: a stale flag would double the byte count. A steady high line with a large divider isolates the latency of the divider and the synchronizer. A four-sample mode with mixed bits exposes the left alignment of short groups. A lazy consumer and a clear that is held high separate overrun from the coincident case of a new byte arriving on a clear. Finally, an enable drop in the middle of a byte shows whether the partial group is discarded.

// File: rtl/osr_pkg.sv
package osr_pkg;
  localparam int CFG_W   = 32;
  localparam int DIV_W   = 16;
  localparam int DIV_LSB = CFG_W - DIV_W;
  localparam int WORD_W  = 8;
  localparam int SYNC_N  = 2;

  // Flag pair kept by the holding register.
  typedef struct packed {
    logic valid;
    logic overrun;
  } osr_flags_t;
endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
  parameter int STAGES = osr_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/osr_tick_div.sv
module osr_tick_div #(
  parameter int DIV_W = osr_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // One strobe every div_lim+1 cycles; >= guards against a lowered limit.
  assign tick = en && (cnt_q >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!en)   cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/osr_sample_pack.sv
module osr_sample_pack #(
  parameter int WORD_W = osr_pkg::WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      tick,
  input  logic                      sample,
  input  logic [$clog2(WORD_W)-1:0] os_code,
  output logic                      word_stb,
  output logic [WORD_W-1:0]         word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_nx;
  logic              last;
  logic [CNT_W-1:0]  pad;

  assign acc_nx   = {acc_q[WORD_W-2:0], sample};
  assign last     = (cnt_q == os_code);
  assign pad      = TOP_IDX - os_code;
  assign word_stb = en && tick && last;
  // Left-align a short group so the earliest sample lands in the MSB.
  assign word     = acc_nx << pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (!en) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_nx;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osr_word_hold.sv
module osr_word_hold #(
  parameter int WORD_W = osr_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word,
  input  logic              clear,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              overrun
);
  osr_pkg::osr_flags_t flags_q;
  logic [WORD_W-1:0]   data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
    end else if (word_stb) begin
      // A clear on the same edge consumed the old byte: no overrun.
      flags_q.valid   <= 1'b1;
      flags_q.overrun <= flags_q.valid && !clear;
      data_q          <= word;
    end else if (clear) begin
      flags_q <= '0;
    end
  end

  assign data    = data_q;
  assign valid   = flags_q.valid;
  assign overrun = flags_q.overrun;
endmodule

// File: rtl/osr_rx_chan.sv
module osr_rx_chan #(
  parameter int CFG_W       = osr_pkg::CFG_W,
  parameter int DIV_W       = osr_pkg::DIV_W,
  parameter int WORD_W      = osr_pkg::WORD_W,
  parameter int SYNC_STAGES = osr_pkg::SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              rx_serial,
  input  logic              rx_clear,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              rx_overrun
);
  localparam int OS_W    = $clog2(WORD_W);
  localparam int CODE_W  = CFG_W - DIV_W;
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(WORD_W - 1);

  logic [DIV_W-1:0]  div_lim;
  logic [CODE_W-1:0] code_raw;
  logic [OS_W-1:0]   os_code;
  logic              line_sync;
  logic              sample_tick;
  logic              word_stb;
  logic [WORD_W-1:0] word;

  assign div_lim  = cfg_word[CFG_W-1 -: DIV_W];
  assign code_raw = cfg_word[CODE_W-1:0];
  assign os_code  = (code_raw > CODE_MAX) ? OS_W'(WORD_W - 1) : code_raw[OS_W-1:0];

  osr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_serial),
    .q     (line_sync)
  );

  osr_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .div_lim (div_lim),
    .tick    (sample_tick)
  );

  osr_sample_pack #(.WORD_W(WORD_W)) i_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (sample_tick),
    .sample   (line_sync),
    .os_code  (os_code),
    .word_stb (word_stb),
    .word     (word)
  );

  osr_word_hold #(.WORD_W(WORD_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .word     (word),
    .clear    (rx_clear),
    .data     (rx_byte),
    .valid    (rx_valid),
    .overrun  (rx_overrun)
  );
endmodule

// File: rtl/osr_rx_chk.sv
module osr_rx_chk #(
  parameter int WORD_W = osr_pkg::WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_clear,
  input logic              rx_valid,
  input logic              rx_overrun,
  input logic [WORD_W-1:0] rx_byte,
  input logic              word_stb,
  input logic              sample_tick
);
  // R7
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clear && !word_stb |=> !rx_valid && !rx_overrun);

  // R6
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(rx_byte));

  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> rx_valid);

  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(word_stb));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && rx_valid && !rx_clear |=> rx_overrun);

  // R8
  no_false_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && rx_clear |=> !rx_overrun);

  // R2
  word_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> sample_tick);

  // R9
  overrun_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);
endmodule

bind osr_rx_chan osr_rx_chk #(.WORD_W(WORD_W)) i_osr_rx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_clear    (rx_clear),
  .rx_valid    (rx_valid),
  .rx_overrun  (rx_overrun),
  .rx_byte     (rx_byte),
  .word_stb    (word_stb),
  .sample_tick (sample_tick)
);

// File: tb/test_osr_rx_chan.sv
module test_osr_rx_chan;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_FAST   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [31:0] cfg_word = '0;
  logic       rx_serial = 1'b0;
  logic       rx_clear = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic       rx_overrun;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_on = 0;
  bit done = 0;
  int cons_mode = 0;
  logic [7:0] got[$];

  // reference model state
  int   m_cnt, m_sc, m_acc, m_word;
  bit   m_valid, m_ov, m_tick, m_stb, m_s;
  logic [7:0] m_byte;
  bit   m_sq[$];
  int   m_div, m_os;

  always #(CLK_PERIOD/2) clk = ~clk;

  osr_rx_chan i_osr_rx_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_word   (cfg_word),
    .rx_serial  (rx_serial),
    .rx_clear   (rx_clear),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sc = 0; m_acc = 0; m_valid = 0; m_ov = 0; m_byte = 8'h00;
      m_sq.delete(); m_sq.push_back(1'b0); m_sq.push_back(1'b0);
    end else begin
      m_div = int'(cfg_word[31:16]);
      m_os  = (cfg_word[15:0] > 16'd7) ? 7 : int'(cfg_word[2:0]);
      m_s   = m_sq.pop_front();
      m_sq.push_back(rx_serial);
      m_tick = en && (m_cnt >= m_div);
      m_stb  = 0;
      if (!en) begin
        m_cnt = 0; m_sc = 0; m_acc = 0;
      end else if (m_tick) begin
        m_cnt = 0;
        m_acc = ((m_acc << 1) | int'(m_s)) & 255;
        if (m_sc == m_os) begin
          m_word = (m_acc << (7 - m_os)) & 255;
          m_stb = 1; m_acc = 0; m_sc = 0;
        end else m_sc++;
      end else m_cnt++;
      if (m_stb) begin
        m_ov = m_valid && !rx_clear;
        m_valid = 1;
        m_byte = 8'(m_word);
      end else if (rx_clear) begin
        m_valid = 0; m_ov = 0;
      end
    end
  end

  // Cycle-by-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      check(rx_valid == m_valid, "R6 R7 valid flag vs model", int'(rx_valid), int'(m_valid));
      check(rx_overrun == m_ov, "R9 overrun flag vs model", int'(rx_overrun), int'(m_ov));
      check(rx_byte == m_byte, "R4 data byte vs model", int'(rx_byte), int'(m_byte));
    end
  end

  // Polling consumer.
  always @(negedge clk) begin
    if (rst_n) begin
      case (cons_mode)
        1: begin
          if (rx_valid) begin got.push_back(rx_byte); rx_clear = 1'b1; end
          else rx_clear = 1'b0;
        end
        2: begin
          rx_clear = 1'b1;
          if (rx_valid) got.push_back(rx_byte);
        end
        default: rx_clear = 1'b0;
      endcase
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      check(0, "R7 watchdog cycles", cyc, 100000);
      finish_run();
    end
  end

  task automatic send_bits(input logic [7:0] val, input int nbits, input int hold);
    for (int i = nbits - 1; i >= 0; i--) begin
      rx_serial = val[i];
      repeat (hold) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int div, input int code);
    return {16'(div), 16'(code)};
  endfunction

  initial begin
    logic [7:0] exp_b;
    int wait_n;
    cfg_word = mk_cfg(DIV_FAST, 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);
    check(rx_overrun == 1'b0, "R1 overrun after reset", int'(rx_overrun), 0);
    check(rx_byte == 8'h00, "R1 byte after reset", int'(rx_byte), 0);
    cmp_on = 1;

    // R5 R7: 0xA3 at 8x with tight poll-and-clear consumer
    cons_mode = 1; got.delete();
    en = 1'b1;
    send_bits(8'hA3, 8, 8 * (DIV_FAST + 1));
    repeat (4) @(negedge clk);
    check(got.size() == 8, "R7 byte count tight poll", got.size(), 8);
    for (int i = 0; i < 8; i++) begin
      exp_b = 8'hA3 >> (7 - i) & 8'h01 ? 8'hFF : 8'h00;
      if (i < got.size()) check(got[i] == exp_b, "R5 A3 sample byte", int'(got[i]), int'(exp_b));
    end
    en = 1'b0;
    repeat (3) @(negedge clk);

    // R2: large divider, steady high line
    cons_mode = 0;
    cfg_word = mk_cfg(239, 7);
    @(negedge clk);
    en = 1'b1; rx_serial = 1'b1; wait_n = 0;
    while (!rx_valid && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n == 8 * 240, "R2 cycles to first byte", wait_n, 8 * 240);
    check(rx_byte == 8'hFF, "R2 steady high byte", int'(rx_byte), 255);
    en = 1'b0;
    cons_mode = 1;
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0, "R7 flag low after clear", int'(rx_valid), 0);

    // R3 R4: four samples per byte, then an out-of-range code
    cfg_word = mk_cfg(DIV_FAST, 3);
    got.delete();
    @(negedge clk);
    en = 1'b1;
    send_bits(8'h0B, 4, 4 * (DIV_FAST + 1));
    repeat (4) @(negedge clk);
    en = 1'b0;
    check(got.size() == 4, "R3 byte count 4x", got.size(), 4);
    for (int i = 0; i < 4; i++) begin
      exp_b = (8'h0B >> (3 - i)) & 8'h01 ? 8'hF0 : 8'h00;
      if (i < got.size()) check(got[i] == exp_b, "R4 left-aligned 4x byte", int'(got[i]), int'(exp_b));
    end
    cfg_word = mk_cfg(DIV_FAST, 200);
    got.delete();
    @(negedge clk);
    en = 1'b1;
    send_bits(8'h02, 2, 8 * (DIV_FAST + 1));
    repeat (4) @(negedge clk);
    en = 1'b0;
    check(got.size() == 2, "R3 clamped code byte count", got.size(), 2);
    if (got.size() == 2) check(got[0] == 8'hFF, "R3 clamped code first byte", int'(got[0]), 255);

    // R9: lazy consumer loses a byte
    cons_mode = 0;
    cfg_word = mk_cfg(DIV_FAST, 7);
    repeat (2) @(negedge clk);
    en = 1'b1;
    send_bits(8'h02, 2, 8 * (DIV_FAST + 1));
    repeat (2) @(negedge clk);
    check(rx_valid == 1'b1, "R9 valid held", int'(rx_valid), 1);
    check(rx_overrun == 1'b1, "R9 overrun raised", int'(rx_overrun), 1);
    check(rx_byte == 8'h00, "R9 newer byte kept", int'(rx_byte), 0);
    en = 1'b0;
    cons_mode = 1;
    repeat (3) @(negedge clk);
    check(rx_overrun == 1'b0, "R9 overrun cleared", int'(rx_overrun), 0);

    // R8 R10: clear held high, bytes arrive on clearing edges
    cons_mode = 2; got.delete();
    @(negedge clk);
    en = 1'b1;
    send_bits(8'h03, 3, 8 * (DIV_FAST + 1));
    repeat (4) @(negedge clk);
    en = 1'b0;
    check(got.size() == 3, "R8 one valid cycle per byte", got.size(), 3);
    if (got.size() == 3) begin
      check(got[0] == 8'h00, "R10 first byte with idle clear", int'(got[0]), 0);
      check(got[2] == 8'hFF, "R8 last byte kept", int'(got[2]), 255);
    end
    check(rx_overrun == 1'b0, "R8 no overrun", int'(rx_overrun), 0);
    check(rx_valid == 1'b0, "R10 valid stays low", int'(rx_valid), 0);

    // R11: enable dropped mid-byte, then clean restart
    cons_mode = 1; got.delete();
    @(negedge clk);
    en = 1'b1; rx_serial = 1'b1;
    repeat (10) @(negedge clk);
    en = 1'b0; rx_serial = 1'b0;
    repeat (5) @(negedge clk);
    check(got.size() == 0, "R11 partial byte discarded", got.size(), 0);
    en = 1'b1;
    send_bits(8'h5A, 8, 8 * (DIV_FAST + 1));
    repeat (4) @(negedge clk);
    en = 1'b0;
    check(got.size() == 8, "R11 byte count after restart", got.size(), 8);
    for (int i = 0; i < 8; i++) begin
      exp_b = (8'h5A >> (7 - i)) & 8'h01 ? 8'hFF : 8'h00;
      if (i < got.size()) check(got[i] == exp_b, "R11 restart byte", int'(got[i]), int'(exp_b));
    end

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule